// File: doc/BRIEF.md
# Two-Position Actuator Sequencer with Motion Watchdog

This block sequences a two-position actuator, such as a pneumatic cylinder, through a fixed cycle. The cycle starts at home, moves outbound, holds at the far end, moves inbound and returns home. Operator requests for outbound and inbound motion start a stroke. The two end-of-travel limit sensors finish it. A per-stroke cycle counter limits how long any motion may last. If a stroke overruns that limit, or the sensors contradict each other, the sequencer trips into a fault state. It stays there until a clear request arrives in a cycle where the plant also reports healthy.

The outputs are Moore-style: the two valve drives and a five-bit status vector are decoded from the state register alone. Inputs only select transitions. The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level, sampled on the rising clock edge. Inputs are expected to be already synchronized and debounced.

Top module: `act_seq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in home state and clears the stroke counter. This applies from any state, including mid-stroke and fault, and the next stroke then gets its full time budget.
- R2: In home state, `cmd_out` moves the sequencer to outbound motion at the next edge. `cmd_in` in home state is ignored.
- R3: In outbound motion, `lim_out` moves the sequencer to the extended hold state at the next edge. `cmd_in` during outbound motion is ignored.
- R4: Outbound motion lasts at most TIMEOUT_CYCLES cycles. If `lim_out` is absent in every one of them, the sequencer trips to fault at the end of the last one. A `lim_out` seen in the last allowed cycle still wins.
- R5: In the extended hold state, `cmd_in` moves the sequencer to inbound motion at the next edge. `cmd_out` there is ignored.
- R6: In inbound motion, `lim_in` returns the sequencer to home. If `lim_in` is absent for TIMEOUT_CYCLES cycles, it trips to fault instead, under the same last-cycle rule as R4.
- R7: Fault is absorbing. It is left, for home, only when `flt_clr` and `plant_ok` are both high in the same cycle. Either one alone, or any command or sensor, keeps it in fault.
- R8: In any state other than fault, `lim_out` and `lim_in` both high at once trips to fault at the next edge, ahead of every other transition.
- R9: `vlv_out` is high only in outbound motion and `vlv_in` only in inbound motion. The two are never high together, and both are low in fault.
- R10: `sts` is one-hot each cycle: bit 0 home, bit 1 outbound, bit 2 extended hold, bit 3 inbound, bit 4 fault. Any unencoded state register value is steered to fault at the next edge.
- R11: The stroke counter restarts on every entry to a motion state. An inbound stroke that follows an outbound stroke which ran to its last allowed cycle still gets the full TIMEOUT_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_out | input | 1 | Request for outbound (extend) stroke |
| cmd_in | input | 1 | Request for inbound (retract) stroke |
| lim_out | input | 1 | Extended end-of-travel sensor |
| lim_in | input | 1 | Retracted end-of-travel sensor |
| flt_clr | input | 1 | Fault clear request |
| plant_ok | input | 1 | Plant reports healthy |
| vlv_out | output | 1 | Extend valve drive |
| vlv_in | output | 1 | Retract valve drive |
| sts | output | 5 | One-hot state indication (see R10) |

## Verification
The status vector and both valves decode the state register directly. A wrong state therefore shows at the ports on the very cycle after the bad edge: a wrong `sts` bit, a valve driven in the wrong phase, or both. A wrong stroke counter stays hidden until a stroke runs long. It then shows as a trip one cycle early or late, or as a sensor in the last allowed cycle losing to the timeout. For that reason the strokes are run right up to their limit, and back-to-back. The bench compares every output against a behavioural model on every clock. Directed checks name each transition and each ignored request.

// File: rtl/act_seq_pkg.sv
package act_seq_pkg;

  localparam int unsigned ST_W = 3;
  localparam int unsigned N_ST = 5;

  typedef enum logic [ST_W-1:0] {
    ST_HOME     = 3'd0,
    ST_OUTBOUND = 3'd1,
    ST_HOLD     = 3'd2,
    ST_INBOUND  = 3'd3,
    ST_TRIP     = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic cmd_out;
    logic cmd_in;
    logic lim_out;
    logic lim_in;
    logic flt_clr;
    logic plant_ok;
  } seq_in_t;

  function automatic logic is_motion(input seq_state_t s);
    return (s == ST_OUTBOUND) || (s == ST_INBOUND);
  endfunction

  function automatic logic sensor_conflict(input seq_in_t i);
    return i.lim_out & i.lim_in;
  endfunction

endpackage

// File: rtl/act_seq_next.sv
module act_seq_next
  import act_seq_pkg::*;
(
  input  seq_state_t st_i,
  input  seq_in_t    in_i,
  input  logic       expired_i,
  output seq_state_t st_o
);

  logic conflict;
  logic clear_ok;

  assign conflict = sensor_conflict(in_i);
  assign clear_ok = in_i.flt_clr & in_i.plant_ok;

  always_comb begin
    st_o = ST_TRIP;
    case (st_i)
      ST_HOME: begin
        if (conflict)         st_o = ST_TRIP;
        else if (in_i.cmd_out) st_o = ST_OUTBOUND;
        else                  st_o = ST_HOME;
      end
      ST_OUTBOUND: begin
        if (conflict)          st_o = ST_TRIP;
        else if (in_i.lim_out) st_o = ST_HOLD;
        else if (expired_i)    st_o = ST_TRIP;
        else                   st_o = ST_OUTBOUND;
      end
      ST_HOLD: begin
        if (conflict)         st_o = ST_TRIP;
        else if (in_i.cmd_in) st_o = ST_INBOUND;
        else                  st_o = ST_HOLD;
      end
      ST_INBOUND: begin
        if (conflict)         st_o = ST_TRIP;
        else if (in_i.lim_in) st_o = ST_HOME;
        else if (expired_i)   st_o = ST_TRIP;
        else                  st_o = ST_INBOUND;
      end
      ST_TRIP: begin
        if (clear_ok) st_o = ST_HOME;
        else          st_o = ST_TRIP;
      end
      default: st_o = ST_TRIP;
    endcase
  end

endmodule

// File: rtl/act_seq_wdog.sv
module act_seq_wdog
  import act_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t st_q_i,
  input  seq_state_t st_d_i,
  output logic       expired_o
);

  localparam int unsigned CW = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          staying;

  assign staying = (st_d_i == st_q_i) && is_motion(st_q_i);

  always_comb begin
    if (staying) cnt_d = cnt_q + CW'(1);
    else         cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign expired_o = is_motion(st_q_i) && (cnt_q >= LAST);

endmodule

// File: rtl/act_seq_decode.sv
module act_seq_decode
  import act_seq_pkg::*;
(
  input  seq_state_t       st_i,
  output logic             vlv_out_o,
  output logic             vlv_in_o,
  output logic [N_ST-1:0]  sts_o
);

  for (genvar g = 0; g < N_ST; g++) begin : g_sts
    assign sts_o[g] = (st_i == seq_state_t'(ST_W'(g)));
  end

  assign vlv_out_o = (st_i == ST_OUTBOUND);
  assign vlv_in_o  = (st_i == ST_INBOUND);

endmodule

// File: rtl/act_seq_ctrl.sv
module act_seq_ctrl
  import act_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_out,
  input  logic       cmd_in,
  input  logic       lim_out,
  input  logic       lim_in,
  input  logic       flt_clr,
  input  logic       plant_ok,
  output logic       vlv_out,
  output logic       vlv_in,
  output logic [4:0] sts
);

  seq_state_t st_q;
  seq_state_t st_d;
  seq_in_t    in_s;
  logic       expired;

  assign in_s = '{cmd_out: cmd_out, cmd_in: cmd_in, lim_out: lim_out,
                  lim_in: lim_in, flt_clr: flt_clr, plant_ok: plant_ok};

  act_seq_next next_i (
    .st_i      (st_q),
    .in_i      (in_s),
    .expired_i (expired),
    .st_o      (st_d)
  );

  act_seq_wdog #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) wdog_i (
    .clk       (clk),
    .rst       (rst),
    .st_q_i    (st_q),
    .st_d_i    (st_d),
    .expired_o (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_HOME;
    else     st_q <= st_d;
  end

  act_seq_decode decode_i (
    .st_i      (st_q),
    .vlv_out_o (vlv_out),
    .vlv_in_o  (vlv_in),
    .sts_o     (sts)
  );

endmodule

// File: rtl/act_seq_chk.sv
module act_seq_chk #(
  parameter int unsigned TIMEOUT_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_out,
  input logic       cmd_in,
  input logic       lim_out,
  input logic       lim_in,
  input logic       flt_clr,
  input logic       plant_ok,
  input logic       vlv_out,
  input logic       vlv_in,
  input logic [4:0] sts
);

  logic        prev_o, prev_i;
  int unsigned run_q, run;
  logic        conflict;

  assign conflict = lim_out & lim_in;
  assign run = ((sts[1] && prev_o) || (sts[3] && prev_i)) ? run_q + 1 : 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_o <= 1'b0;
      prev_i <= 1'b0;
      run_q  <= 0;
    end else begin
      prev_o <= sts[1];
      prev_i <= sts[3];
      run_q  <= run;
    end
  end

  AST_RESET_HOME: assert property (@(posedge clk) rst |=> sts == 5'b00001); // R1
  AST_OUT_START: assert property (@(posedge clk) disable iff (rst)
    sts[0] && cmd_out && !conflict |=> sts[1]); // R2
  AST_OUT_DONE: assert property (@(posedge clk) disable iff (rst)
    sts[1] && lim_out && !lim_in |=> sts[2]); // R3
  AST_OUT_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    sts[1] && run == TIMEOUT_CYCLES - 1 && !lim_out |=> sts[4]); // R4
  AST_STROKE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (sts[1] || sts[3]) |-> run < TIMEOUT_CYCLES); // R11
  AST_IN_START: assert property (@(posedge clk) disable iff (rst)
    sts[2] && cmd_in && !conflict |=> sts[3]); // R5
  AST_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    sts[3] && lim_in && !lim_out |=> sts[0]); // R6
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    sts[4] && !(flt_clr && plant_ok) |=> sts[4]); // R7
  AST_FAULT_EXIT: assert property (@(posedge clk) disable iff (rst)
    sts[4] && flt_clr && plant_ok |=> sts[0]); // R7
  AST_SENSOR_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    !sts[4] && conflict |=> sts[4]); // R8
  AST_VALVE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(vlv_out && vlv_in)); // R9
  AST_VALVE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (vlv_out |-> sts[1]) and (vlv_in |-> sts[3])); // R9
  AST_STS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(sts) == 1); // R10

endmodule

bind act_seq_ctrl act_seq_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .cmd_out(cmd_out), .cmd_in(cmd_in),
  .lim_out(lim_out), .lim_in(lim_in), .flt_clr(flt_clr), .plant_ok(plant_ok),
  .vlv_out(vlv_out), .vlv_in(vlv_in), .sts(sts)
);

// File: tb/act_seq_ctrl_tb.sv
`timescale 1ns/1ps
module act_seq_ctrl_tb_top;

  localparam int T = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_out = 0, cmd_in = 0, lim_out = 0, lim_in = 0, flt_clr = 0, plant_ok = 0;
  logic vlv_out, vlv_in;
  logic [4:0] sts;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_st = 0;
  int m_run = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  act_seq_ctrl #(.TIMEOUT_CYCLES(T)) dut_i (
    .clk(clk), .rst(rst), .cmd_out(cmd_out), .cmd_in(cmd_in),
    .lim_out(lim_out), .lim_in(lim_in), .flt_clr(flt_clr), .plant_ok(plant_ok),
    .vlv_out(vlv_out), .vlv_in(vlv_in), .sts(sts)
  );

  // Behavioural reference: 0 home, 1 outbound, 2 hold, 3 inbound, 4 fault
  always @(posedge clk) begin
    int nx;
    started = 1;
    if (rst) begin
      m_st = 0; m_run = 0;
    end else begin
      nx = m_st;
      if (m_st != 4 && lim_out && lim_in) nx = 4;
      else if (m_st == 0 && cmd_out) nx = 1;
      else if (m_st == 1 && lim_out) nx = 2;
      else if (m_st == 1 && m_run >= T - 1) nx = 4;
      else if (m_st == 2 && cmd_in) nx = 3;
      else if (m_st == 3 && lim_in) nx = 0;
      else if (m_st == 3 && m_run >= T - 1) nx = 4;
      else if (m_st == 4 && flt_clr && plant_ok) nx = 0;
      m_run = (nx == m_st && (nx == 1 || nx == 3)) ? m_run + 1 : 0;
      m_st = nx;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (sts !== 5'(1 << m_st)) begin
        errors++;
        $display("FAIL R10 cycle %0d: sts=%b expected=%b", cyc, sts, 5'(1 << m_st));
      end
      checks++;
      if (vlv_out !== (m_st == 1) || vlv_in !== (m_st == 3)) begin
        errors++;
        $display("FAIL R9 cycle %0d: valves=%b%b expected=%b%b", cyc, vlv_out, vlv_in,
                 m_st == 1, m_st == 3);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=%0d cycles expected<20000", cyc);
      finish_run();
    end
  end

  task automatic expect_sts(input logic [4:0] exp, input string req);
    checks++;
    if (sts !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: sts=%b expected=%b", req, cyc, sts, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_in();
    cmd_out = 0; cmd_in = 0; lim_out = 0; lim_in = 0; flt_clr = 0; plant_ok = 0;
  endtask

  task automatic go_hold();
    cmd_out = 1; tick(1); cmd_out = 0;
    tick(1); lim_out = 1; tick(1); lim_out = 0;
  endtask

  task automatic clear_fault();
    flt_clr = 1; plant_ok = 1; tick(1); clear_in();
  endtask

  initial begin
    tick(3);
    rst = 0;
    expect_sts(5'b00001, "R1 after reset");
    checks++;
    if (vlv_out !== 0 || vlv_in !== 0) begin
      errors++;
      $display("FAIL R1: valves=%b%b expected=00", vlv_out, vlv_in);
    end

    cmd_in = 1; tick(1); cmd_in = 0;
    expect_sts(5'b00001, "R2 cmd_in ignored at home");
    cmd_out = 1; tick(1); cmd_out = 0;
    expect_sts(5'b00010, "R2 start outbound");
    cmd_in = 1; tick(1); cmd_in = 0;
    expect_sts(5'b00010, "R3 cmd_in ignored outbound");
    lim_out = 1; tick(1); lim_out = 0;
    expect_sts(5'b00100, "R3 reach hold");
    cmd_out = 1; tick(1); cmd_out = 0;
    expect_sts(5'b00100, "R5 cmd_out ignored in hold");
    cmd_in = 1; tick(1); cmd_in = 0;
    expect_sts(5'b01000, "R5 start inbound");
    tick(2); lim_in = 1; tick(1); lim_in = 0;
    expect_sts(5'b00001, "R6 back home");

    // outbound timeout
    cmd_out = 1; tick(1); cmd_out = 0;
    tick(T - 1);
    expect_sts(5'b00010, "R4 still outbound in last cycle");
    tick(1);
    expect_sts(5'b10000, "R4 timeout trip");

    flt_clr = 1; tick(1); clear_in();
    expect_sts(5'b10000, "R7 clear without health");
    plant_ok = 1; cmd_out = 1; tick(1); clear_in();
    expect_sts(5'b10000, "R7 health without clear");
    lim_in = 1; cmd_in = 1; tick(2); clear_in();
    expect_sts(5'b10000, "R7 sensors/commands ignored in fault");
    clear_fault();
    expect_sts(5'b00001, "R7 clear and health exit");

    // sensor in last allowed cycle, then full budget inbound
    cmd_out = 1; tick(1); cmd_out = 0;
    tick(T - 1); lim_out = 1; tick(1); lim_out = 0;
    expect_sts(5'b00100, "R4 sensor wins in last cycle");
    cmd_in = 1; tick(1); cmd_in = 0;
    tick(T - 1);
    expect_sts(5'b01000, "R11 inbound full budget");
    lim_in = 1; tick(1); lim_in = 0;
    expect_sts(5'b00001, "R11 inbound done in last cycle");

    // inbound timeout
    go_hold();
    cmd_in = 1; tick(1); cmd_in = 0;
    tick(T);
    expect_sts(5'b10000, "R6 inbound timeout trip");
    clear_fault();

    // sensor conflict
    lim_out = 1; lim_in = 1; tick(1); clear_in();
    expect_sts(5'b10000, "R8 conflict at home");
    clear_fault();
    cmd_out = 1; tick(1); cmd_out = 0;
    lim_out = 1; lim_in = 1; tick(1); clear_in();
    expect_sts(5'b10000, "R8 conflict outbound");
    clear_fault();
    go_hold();
    lim_out = 1; lim_in = 1; cmd_in = 1; tick(1); clear_in();
    expect_sts(5'b10000, "R8 conflict beats cmd_in in hold");

    // reset from fault, and mid-stroke reset restores full budget
    rst = 1; tick(1); rst = 0;
    expect_sts(5'b00001, "R1 reset leaves fault");
    cmd_out = 1; tick(1); cmd_out = 0;
    tick(T - 3);
    rst = 1; tick(1); rst = 0;
    expect_sts(5'b00001, "R1 reset mid-stroke");
    cmd_out = 1; tick(1); cmd_out = 0;
    tick(T - 1);
    expect_sts(5'b00010, "R1 counter cleared by reset");
    tick(1);
    expect_sts(5'b10000, "R4 trip after full budget");
    clear_fault();
    tick(2);
    finish_run();
  end

endmodule